// File: doc/BRIEF.md
# Ethernet Frame Generator

This block builds complete Ethernet frames on the transmit side and sends them one octet per clock on an 8-bit byte-wide transmit interface. The interface is a data bus plus a transmit-enable strobe. A single byte counter walks the frame from the first preamble octet to the last check-sequence octet. At each step the counter selects which field octet is driven. An embedded reflected CRC-32 unit follows the covered octets and supplies the trailer.

The surrounding logic presents the destination address, source address, type value and payload length, and then pulses `start`. The block captures these values when it accepts the pulse. It fetches payload octets through an index/strobe pair, padding short payloads with zeros and clamping long ones. It marks the final octet with a one-cycle `done`. After each frame it enforces a minimum idle gap before another start is honoured.

Top module: `efg_frame_gen`

## Requirements
- R1: While `rst_n` is low, `tx_en`, `done` and `pay_rd` are 0 and `txd` is 0x00, whatever `start` does.
- R2: An accepted `start` (high at a rising edge) makes `tx_en` rise two clock cycles later. The first 7 octets on `txd` are 0x55, and the eighth is 0xD5.
- R3: Octets 8 to 21 of the frame carry the header in this order:
  - octets 8 to 13 are `dst_mac`, bits [47:40] first;
  - octets 14 to 19 are `src_mac`, bits [47:40] first;
  - octets 20 and 21 are `eth_type`, bits [15:8] first.
  - The values used are the ones present on the accepting edge.
- R4: Payload octet i (i from 0) is requested by driving `pay_idx` = i with `pay_rd` = 1. The value on `pay_data` in that same cycle is driven on `txd` in the next cycle, as frame octet 22+i. The requests are issued for i = 0 to L-1, in order, where L is the clamped length of R6.
- R5: When `pay_len` is below 46, zero octets follow the payload until 46 payload octets have been sent. No `pay_rd` request is made for these padding octets.
- R6: A `pay_len` above 1500 is treated as 1500.
- R7: The last 4 octets are the frame check sequence, computed as follows:
  - The CRC-32 (reflected polynomial 0xEDB88320, each octet fed LSB first) starts from 0xFFFFFFFF.
  - It covers every octet from the first destination octet through the last payload or padding octet.
  - The result is inverted and sent least-significant byte first.
- R8: `tx_en` stays high for exactly 26 + P cycles, where P is the padded and clamped payload length. `done` is high for exactly one cycle, together with the last check-sequence octet.
- R9: A `start` while a frame is in progress has no effect. The frame in progress is unchanged, and no extra frame follows it.
- R10: After a frame, `start` is ignored until `tx_en` has been low for 12 cycles. With `start` held high, the next frame begins after an idle gap of exactly 12 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to launch one frame |
| dst_mac | input | 48 | Destination address |
| src_mac | input | 48 | Source address |
| eth_type | input | 16 | Type field value |
| pay_len | input | 11 | Requested payload length in octets |
| pay_data | input | 8 | Payload octet for the requested index |
| pay_rd | output | 1 | Payload octet request strobe |
| pay_idx | output | 11 | Index of the requested payload octet |
| txd | output | 8 | Transmit octet |
| tx_en | output | 1 | Transmit enable |
| done | output | 1 | Marks the last octet of a frame |

## Verification
On every cycle, the embedded assertions check several properties:
- a frame's enable run length matches its padded length;
- `done` lines up with the final octet;
- each frame opens with a preamble octet;
- padding positions carry zero;
- the CRC register holds its seed at the first covered octet;
- payload requests are always followed by a transmitted octet;
- every gap between frames is at least 12 cycles.

The actual octet contents can only be shown by the bench's scenarios, which compare whole captured frames against a reference builder and CRC. This includes header order, payload mapping, the padding and clamping boundaries (0, 17, 46, 1500, 1501 and 2047 octets) and the check sequence. The same holds for whether mid-frame and in-gap starts are really ignored, and whether the gap under a held start is exactly 12 cycles.

// File: rtl/efg_pkg.sv
package efg_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;
  localparam logic [7:0]  PRE_OCTET = 8'h55;
  localparam logic [7:0]  SFD_OCTET = 8'hD5;

  localparam int PRE_LEN  = 7;
  localparam int SFD_POS  = 7;
  localparam int DA_POS   = 8;
  localparam int SA_POS   = 14;
  localparam int TY_POS   = 20;
  localparam int PAY_POS  = 22;
  localparam int FCS_LEN  = 4;

  typedef enum logic [2:0] {
    F_PRE  = 3'd0,
    F_SFD  = 3'd1,
    F_DA   = 3'd2,
    F_SA   = 3'd3,
    F_TYPE = 3'd4,
    F_PAY  = 3'd5,
    F_PAD  = 3'd6,
    F_FCS  = 3'd7
  } field_e;

  function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                             input logic [7:0]  octet);
    logic [31:0] c;
    c = crc_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ octet[b]) c = (c >> 1) ^ CRC_POLY;
      else                 c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/efg_seq.sv
module efg_seq
  import efg_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MIN_PAY = 46,
  parameter int MAX_PAY = 1500,
  parameter int IFG     = 12,
  localparam int POS_W  = $clog2(PAY_POS + MAX_PAY + FCS_LEN + 1),
  localparam int GAP_W  = $clog2(IFG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] pay_len,
  output logic             launch,
  output logic             busy,
  output logic             at_end,
  output field_e           fld,
  output logic [2:0]       fidx,
  output logic [LEN_W-1:0] pay_idx,
  output logic [LEN_W-1:0] eff_len
);

  localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(IFG - 1);
  localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_PAY);
  localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_PAY);

  logic             busy_q, busy_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [LEN_W-1:0] raw_q, raw_d;
  logic [LEN_W-1:0] eff_q, eff_d;
  logic [LEN_W-1:0] len_clamp, len_eff;
  logic [POS_W-1:0] last_pos, pay_end, pay_off, fcs_off;

  always_comb begin
    len_clamp = (pay_len > MAX_L) ? MAX_L : pay_len;
    len_eff   = (len_clamp < MIN_L) ? MIN_L : len_clamp;
  end

  assign launch   = start && !busy_q && (gap_q == GAP_TOP);
  assign pay_end  = POS_W'(PAY_POS) + POS_W'(eff_q);
  assign last_pos = pay_end + POS_W'(FCS_LEN - 1);
  assign at_end   = busy_q && (pos_q == last_pos);

  always_comb begin
    busy_d = busy_q;
    pos_d  = pos_q;
    gap_d  = gap_q;
    raw_d  = raw_q;
    eff_d  = eff_q;
    if (launch) begin
      busy_d = 1'b1;
      pos_d  = '0;
      raw_d  = len_clamp;
      eff_d  = len_eff;
    end else if (busy_q) begin
      if (at_end) begin
        busy_d = 1'b0;
        gap_d  = '0;
      end else begin
        pos_d = pos_q + POS_W'(1);
      end
    end else if (gap_q != GAP_TOP) begin
      gap_d = gap_q + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      gap_q  <= GAP_TOP;
      raw_q  <= '0;
      eff_q  <= MIN_L;
    end else begin
      busy_q <= busy_d;
      pos_q  <= pos_d;
      gap_q  <= gap_d;
      raw_q  <= raw_d;
      eff_q  <= eff_d;
    end
  end

  assign pay_off = pos_q - POS_W'(PAY_POS);
  assign fcs_off = pos_q - pay_end;

  always_comb begin
    fld     = F_PRE;
    fidx    = '0;
    pay_idx = '0;
    if (pos_q < POS_W'(PRE_LEN)) begin
      fld = F_PRE;
    end else if (pos_q == POS_W'(SFD_POS)) begin
      fld = F_SFD;
    end else if (pos_q < POS_W'(SA_POS)) begin
      fld  = F_DA;
      fidx = 3'(pos_q - POS_W'(DA_POS));
    end else if (pos_q < POS_W'(TY_POS)) begin
      fld  = F_SA;
      fidx = 3'(pos_q - POS_W'(SA_POS));
    end else if (pos_q < POS_W'(PAY_POS)) begin
      fld  = F_TYPE;
      fidx = 3'(pos_q - POS_W'(TY_POS));
    end else if (pos_q < pay_end) begin
      pay_idx = LEN_W'(pay_off);
      fld     = (LEN_W'(pay_off) < raw_q) ? F_PAY : F_PAD;
    end else begin
      fld  = F_FCS;
      fidx = 3'(fcs_off);
    end
  end

  assign busy    = busy_q;
  assign eff_len = eff_q;

  // R9: a running frame advances one step per cycle no matter what start does
  assert_run_advances_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_end) |=> (busy_q && (pos_q == $past(pos_q) + POS_W'(1))));

  // R6: the captured length never exceeds the clamp or falls below the pad floor
  assert_len_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(launch) |-> ((eff_q <= MAX_L) && (eff_q >= MIN_L) && (raw_q <= MAX_L)));

endmodule

// File: rtl/efg_crc.sv
module efg_crc
  import efg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed,
  input  logic        en,
  input  logic [7:0]  octet,
  output logic [31:0] crc
);

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (seed)    crc_d = CRC_SEED;
    else if (en) crc_d = crc32_step(crc_q, octet);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R7: a clear request always lands on the seed value
  assert_seed_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (crc_q == CRC_SEED));

endmodule

// File: rtl/efg_octet_sel.sv
module efg_octet_sel
  import efg_pkg::*;
(
  input  field_e      fld,
  input  logic [2:0]  fidx,
  input  logic [47:0] da,
  input  logic [47:0] sa,
  input  logic [15:0] ty,
  input  logic [7:0]  pay_data,
  input  logic [31:0] crc,
  output logic [7:0]  octet
);

  logic [5:0]  mac_sh;
  logic [47:0] da_sh, sa_sh;
  logic [15:0] ty_sh;
  logic [31:0] fcs_sh;

  always_comb begin
    mac_sh = {3'd5 - fidx, 3'b000};
    da_sh  = da >> mac_sh;
    sa_sh  = sa >> mac_sh;
    ty_sh  = fidx[0] ? ty : (ty >> 8);
    fcs_sh = (~crc) >> {fidx[1:0], 3'b000};
    case (fld)
      F_PRE:   octet = PRE_OCTET;
      F_SFD:   octet = SFD_OCTET;
      F_DA:    octet = da_sh[7:0];
      F_SA:    octet = sa_sh[7:0];
      F_TYPE:  octet = ty_sh[7:0];
      F_PAY:   octet = pay_data;
      F_PAD:   octet = 8'h00;
      F_FCS:   octet = fcs_sh[7:0];
      default: octet = 8'h00;
    endcase
  end

endmodule

// File: rtl/efg_frame_gen.sv
module efg_frame_gen
  import efg_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MIN_PAY = 46,
  parameter int MAX_PAY = 1500,
  parameter int IFG     = 12,
  localparam int RUN_W  = $clog2(PAY_POS + MAX_PAY + FCS_LEN + 2),
  localparam int GAP_W  = $clog2(IFG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [47:0]      dst_mac,
  input  logic [47:0]      src_mac,
  input  logic [15:0]      eth_type,
  input  logic [LEN_W-1:0] pay_len,
  input  logic [7:0]       pay_data,
  output logic             pay_rd,
  output logic [LEN_W-1:0] pay_idx,
  output logic [7:0]       txd,
  output logic             tx_en,
  output logic             done
);

  logic             launch, busy, at_end;
  field_e           fld;
  logic [2:0]       fidx;
  logic [LEN_W-1:0] eff_len;
  logic [31:0]      crc;
  logic [7:0]       octet;
  logic             crc_en;

  logic [47:0] da_q, da_d, sa_q, sa_d;
  logic [15:0] ty_q, ty_d;
  logic [7:0]  txd_q, txd_d;
  logic        txen_q, txen_d, done_q, done_d;

  efg_seq #(
    .LEN_W(LEN_W), .MIN_PAY(MIN_PAY), .MAX_PAY(MAX_PAY), .IFG(IFG)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pay_len(pay_len),
    .launch(launch), .busy(busy), .at_end(at_end), .fld(fld), .fidx(fidx),
    .pay_idx(pay_idx), .eff_len(eff_len)
  );

  efg_octet_sel u_sel (
    .fld(fld), .fidx(fidx), .da(da_q), .sa(sa_q), .ty(ty_q),
    .pay_data(pay_data), .crc(crc), .octet(octet)
  );

  assign crc_en = busy && (fld inside {F_DA, F_SA, F_TYPE, F_PAY, F_PAD});

  efg_crc u_crc (
    .clk(clk), .rst_n(rst_n), .seed(launch), .en(crc_en), .octet(octet),
    .crc(crc)
  );

  assign pay_rd = busy && (fld == F_PAY);

  always_comb begin
    da_d   = launch ? dst_mac  : da_q;
    sa_d   = launch ? src_mac  : sa_q;
    ty_d   = launch ? eth_type : ty_q;
    txen_d = busy;
    txd_d  = busy ? octet : 8'h00;
    done_d = at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      da_q   <= '0;
      sa_q   <= '0;
      ty_q   <= '0;
      txd_q  <= '0;
      txen_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      da_q   <= da_d;
      sa_q   <= sa_d;
      ty_q   <= ty_d;
      txd_q  <= txd_d;
      txen_q <= txen_d;
      done_q <= done_d;
    end
  end

  assign txd   = txd_q;
  assign tx_en = txen_q;
  assign done  = done_q;

  // Checker state: length of the current enable run and of the idle gap
  logic [RUN_W-1:0] run_cnt;
  logic [GAP_W-1:0] idle_cnt;
  logic             seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt    <= '0;
      idle_cnt   <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (txen_q) begin
        run_cnt    <= run_cnt + RUN_W'(1);
        idle_cnt   <= '0;
        seen_frame <= 1'b1;
      end else begin
        run_cnt <= '0;
        if (idle_cnt != GAP_W'(IFG)) idle_cnt <= idle_cnt + GAP_W'(1);
      end
    end
  end

  // R8: each enable run equals header, trailer and padded payload
  assert_run_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!txen_q && $past(txen_q)) |->
      (run_cnt == RUN_W'(PAY_POS + FCS_LEN) + RUN_W'(eff_len)));

  // R8: done accompanies the final octet and enable drops right after it
  assert_done_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (txen_q ##1 !txen_q));

  // R2: every frame opens with a preamble octet
  assert_opens_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen_q) |-> (txd_q == PRE_OCTET));

  // R4: a payload request is always followed by a transmitted octet
  assert_read_sent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pay_rd |=> txen_q);

  // R5: padding positions go out as zero
  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (fld == F_PAD)) |=> (txd_q == 8'h00));

  // R7: the CRC is seeded when the first covered octet is reached
  assert_crc_seeded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (fld == F_DA) && (fidx == 3'd0)) |-> (crc == CRC_SEED));

  // R10: consecutive frames are separated by the minimum idle gap
  assert_min_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(txen_q) && seen_frame) |-> (idle_cnt == GAP_W'(IFG)));

endmodule

// File: tb/efg_frame_gen_bench.sv
module efg_frame_gen_bench;

  localparam int LEN_W = 11;
  localparam int MINP  = 46;
  localparam int MAXP  = 1500;
  localparam int GAP   = 12;

  logic             clk, rst_n, start;
  logic [47:0]      dst_mac, src_mac;
  logic [15:0]      eth_type;
  logic [LEN_W-1:0] pay_len;
  logic [7:0]       pay_data;
  logic             pay_rd;
  logic [LEN_W-1:0] pay_idx;
  logic [7:0]       txd;
  logic             tx_en, done;

  logic [7:0] key;

  int checks, errors;
  int cyc;
  bit finished;

  efg_frame_gen u_efg_frame_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_mac(dst_mac),
    .src_mac(src_mac), .eth_type(eth_type), .pay_len(pay_len),
    .pay_data(pay_data), .pay_rd(pay_rd), .pay_idx(pay_idx),
    .txd(txd), .tx_en(tx_en), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pf(input logic [LEN_W-1:0] i, input logic [7:0] k);
    return i[7:0] ^ k ^ {i[10:8], 5'd0};
  endfunction

  assign pay_data = pf(pay_idx, key);

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ d[k];
      r  = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  // Monitor
  logic [7:0] cap [0:2047];
  int cap_len, first_cyc, done_cnt, done_at, idle, gap_last, frame_cnt;
  int rd_cnt, rd_err, stray_done;
  bit in_frame, any_tx;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en) begin
        any_tx = 1'b1;
        if (!in_frame) begin
          in_frame = 1'b1; cap_len = 0; first_cyc = cyc; gap_last = idle;
          done_cnt = 0; done_at = -1; rd_cnt = 0; rd_err = 0;
        end
        cap[cap_len] = txd;
        if (done) begin done_cnt++; done_at = cap_len; end
        cap_len++;
        idle = 0;
      end else begin
        if (in_frame) begin in_frame = 1'b0; frame_cnt++; end
        if (done) stray_done++;
        idle++;
      end
      if (pay_rd) begin
        if (pay_idx != LEN_W'(rd_cnt)) rd_err++;
        rd_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_frame(input logic [47:0] da, input logic [47:0] sa,
                             input logic [15:0] ty, input int len,
                             input logic [7:0] k, input int start_c);
    int L, P, tot, bad, bad_a, bad_e;
    logic [7:0] e [0:2047];
    logic [31:0] c;
    L = (len > MAXP) ? MAXP : len;
    P = (L < MINP) ? MINP : L;
    tot = 26 + P;
    for (int i = 0; i < 7; i++) e[i] = 8'h55;
    e[7] = 8'hD5;
    for (int i = 0; i < 6; i++) e[8 + i]  = da[47 - 8*i -: 8];
    for (int i = 0; i < 6; i++) e[14 + i] = sa[47 - 8*i -: 8];
    e[20] = ty[15:8]; e[21] = ty[7:0];
    for (int i = 0; i < P; i++) e[22 + i] = (i < L) ? pf(LEN_W'(i), k) : 8'h00;
    c = 32'hFFFFFFFF;
    for (int i = 8; i < 22 + P; i++) c = ref_crc(c, e[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) e[22 + P + i] = c[8*i +: 8];

    chk(cap_len == tot, (len > MAXP) ? "R6" : "R8", "enable length", cap_len, tot);
    chk(done_cnt == 1 && done_at == tot - 1, "R8", "done position", done_at, tot - 1);
    if (start_c >= 0)
      chk(first_cyc - start_c == 2, "R2", "start latency", first_cyc - start_c, 2);
    // compare regions
    bad = 0; bad_a = 0; bad_e = 0;
    for (int i = 0; i < 8; i++) if (cap[i] != e[i] && bad == 0) begin bad = 1; bad_a = cap[i]; bad_e = e[i]; end
    chk(bad == 0, "R2", "preamble/delimiter octet", bad_a, bad_e);
    bad = 0;
    for (int i = 8; i < 22; i++) if (cap[i] != e[i] && bad == 0) begin bad = 1; bad_a = cap[i]; bad_e = e[i]; end
    chk(bad == 0, "R3", "header octet", bad_a, bad_e);
    bad = 0;
    for (int i = 0; i < L; i++) if (cap[22+i] != e[22+i] && bad == 0) begin bad = 1; bad_a = cap[22+i]; bad_e = e[22+i]; end
    chk(bad == 0, "R4", "payload octet", bad_a, bad_e);
    chk(rd_cnt == L && rd_err == 0, "R4", "payload request count", rd_cnt, L);
    if (len < MINP) begin
      bad = 0;
      for (int i = L; i < P; i++) if (cap[22+i] != 8'h00 && bad == 0) begin bad = 1; bad_a = cap[22+i]; end
      chk(bad == 0, "R5", "padding octet", bad_a, 0);
    end
    bad = 0;
    for (int i = 0; i < 4; i++) if (cap[22+P+i] != e[22+P+i] && bad == 0) begin bad = 1; bad_a = cap[22+P+i]; bad_e = e[22+P+i]; end
    chk(bad == 0, "R7", "check sequence octet", bad_a, bad_e);
  endtask

  task automatic launch_cfg(input logic [47:0] da, input logic [47:0] sa,
                            input logic [15:0] ty, input int len,
                            input logic [7:0] k, output int sc);
    @(negedge clk);
    dst_mac = da; src_mac = sa; eth_type = ty; pay_len = LEN_W'(len); key = k;
    start = 1'b1; sc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_frame(input logic [47:0] da, input logic [47:0] sa,
                           input logic [15:0] ty, input int len, input logic [7:0] k);
    int sc, tgt;
    tgt = frame_cnt + 1;
    launch_cfg(da, sa, ty, len, k, sc);
    wait (frame_cnt == tgt);
    check_frame(da, sa, ty, len, k, sc);
    repeat (GAP + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    int sc, tgt, fc, rlen;
    logic [47:0] rda, rsa;
    logic [15:0] rty;
    logic [7:0] rk;
    checks = 0; errors = 0; cyc = 0; finished = 0;
    cap_len = 0; idle = 0; frame_cnt = 0; in_frame = 0; any_tx = 0;
    rd_cnt = 0; rd_err = 0; stray_done = 0; gap_last = 0;
    s = $urandom(32'd2024);
    rst_n = 1'b0; start = 1'b1;
    dst_mac = 48'h0; src_mac = 48'h0; eth_type = 16'h0; pay_len = '0; key = 8'h00;
    repeat (4) @(negedge clk);
    // R1: quiet outputs during reset even with start asserted
    chk(tx_en == 0 && done == 0 && pay_rd == 0 && txd == 8'h00, "R1",
        "reset outputs", {tx_en, done, pay_rd}, 0);
    start = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_en == 0 && txd == 8'h00, "R1", "idle after reset", tx_en, 0);

    // directed lengths
    run_frame(48'h0102_0304_0506, 48'hA1A2_A3A4_A5A6, 16'h0800, 46, 8'h3C);
    run_frame(48'hFFFF_FFFF_FFFF, 48'h0011_2233_4455, 16'h86DD, 0, 8'h5A);
    run_frame(48'h1234_5678_9ABC, 48'hDEF0_1357_9BDF, 16'h88B5, 17, 8'hC3);
    run_frame(48'h0A0B_0C0D_0E0F, 48'h1020_3040_5060, 16'h0806, 1500, 8'h71);
    run_frame(48'h7766_5544_3322, 48'h1100_FFEE_DDCC, 16'h1234, 1501, 8'h0F);
    run_frame(48'h0000_0000_0001, 48'h8000_0000_0000, 16'hFFFF, 2047, 8'hE9);

    // random frames
    for (int n = 0; n < 6; n++) begin
      rda = {$urandom, $urandom} ; rsa = {$urandom, $urandom};
      rty = 16'($urandom); rk = 8'($urandom);
      rlen = int'($urandom % 1701);
      run_frame(rda, rsa, rty, rlen, rk);
    end

    // R9: start during a frame is ignored
    tgt = frame_cnt + 1;
    launch_cfg(48'hCAFE_0000_BEEF, 48'h0101_0202_0303, 16'h0101, 60, 8'h99, sc);
    repeat (40) @(negedge clk);
    dst_mac = 48'h0; eth_type = 16'h0; pay_len = LEN_W'(5);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (frame_cnt == tgt);
    check_frame(48'hCAFE_0000_BEEF, 48'h0101_0202_0303, 16'h0101, 60, 8'h99, sc);
    any_tx = 1'b0;
    repeat (60) @(negedge clk);
    chk(!any_tx && frame_cnt == tgt, "R9", "extra frame after mid-frame start",
        frame_cnt, tgt);

    // R10: start inside the gap is ignored
    tgt = frame_cnt + 1;
    launch_cfg(48'h0202_0202_0202, 48'h0303_0303_0303, 16'h4242, 50, 8'h11, sc);
    wait (frame_cnt == tgt);
    check_frame(48'h0202_0202_0202, 48'h0303_0303_0303, 16'h4242, 50, 8'h11, sc);
    @(negedge clk);
    any_tx = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk(!any_tx && frame_cnt == tgt, "R10", "start in gap ignored", frame_cnt, tgt);

    // R10: held start gives back-to-back frames with exact gap
    fc = frame_cnt;
    launch_cfg(48'h5555_AAAA_5555, 48'h9999_6666_9999, 16'h7777, 48, 8'h42, sc);
    start = 1'b1;
    wait (frame_cnt == fc + 1);
    check_frame(48'h5555_AAAA_5555, 48'h9999_6666_9999, 16'h7777, 48, 8'h42, sc);
    wait (in_frame == 1'b1);
    @(negedge clk);
    start = 1'b0;
    chk(gap_last == GAP, "R10", "idle gap with held start", gap_last, GAP);
    wait (frame_cnt == fc + 2);
    check_frame(48'h5555_AAAA_5555, 48'h9999_6666_9999, 16'h7777, 48, 8'h42, -1);
    repeat (30) @(negedge clk);
    chk(frame_cnt == fc + 2 && stray_done == 0, "R8", "no stray frame or done",
        frame_cnt, fc + 2);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule